// File: doc/BRIEF.md
# Packed Pixel Format Converter

This block reshapes packed pixel data held in 64-bit SIMD registers. A 9-bit opcode selects one of five conversions. Three of them are saturating packs. Each pack applies a programmable left-shift scale, then a fixed arithmetic right shift, then clamps the value into a narrower lane. The other two are byte rearrangements: one widens bytes into 16-bit fixed-point lanes, the other interleaves two 32-bit operands. The scale amount comes from the low byte of a global status register, which the surrounding pipeline passes in with each operation.

The conversion itself is combinational. Its outcome is captured in an output register on the clock edge that samples `in_valid`, so a result appears exactly one cycle after its operands. A two-state controller tracks whether the register holds a fresh result. In state `ST_EMPTY`, `out_valid` is low. In state `ST_FULL`, the register was loaded on the last edge. The transition taken on every edge is `GO_FULL` when `in_valid` is high and `GO_EMPTY` when it is low. An opcode outside the five defined values loads a zero result and raises `illegal_op`.

Top module: `pixfmt_conv`

## Requirements
- R1: Opcode 0x03B (4-lane pack) treats each 16-bit lane i of `src_b` as signed. It shifts the lane left by the scale, shifts it arithmetically right by 7, clamps it to 0..255 and writes it to result byte i. Result bits [63:32] are zero.
- R2: The scale is `status_lo[6:3]` for opcode 0x03B, so bit 7 has no effect there. For opcodes 0x03A and 0x03D the scale is `status_lo[7:3]`.
- R3: Opcode 0x03A (2-lane byte pack) first forms `src_a` shifted left by 8 with bytes 0 and 4 cleared. Each signed 32-bit word w of `src_b` is shifted left by the scale, shifted right by 23 and clamped to 0..255. That value fills byte 4w of the result.
- R4: Opcode 0x03D (fixed-point pack) shifts each signed 32-bit word w of `src_b` left by the scale, then right by 16. It clamps the value to -32768..32767 and writes it to result bits [16w+15:16w]. Bits [63:32] are zero.
- R5: Opcode 0x04D (expand) takes byte i of `src_b[31:0]`, zero-extends it and shifts it left by 4, then places it in result bits [16i+15:16i]. `src_a` and `src_b[63:32]` have no effect.
- R6: Opcode 0x04B (merge) sets result byte 2i to `src_b` byte i and result byte 2i+1 to `src_a` byte i, for i = 0..3. The upper halves of both operands have no effect.
- R7: Scaled values lose no bits before saturation. An input that a narrower intermediate would wrap must still saturate to the correct bound.
- R8: `result` and `illegal_op` load on the edge where `in_valid` is high, and `out_valid` is high in the following cycle only. While `in_valid` is low, `out_valid` is low, and `result` and `illegal_op` hold their values whatever the other inputs are.
- R9: Any other opcode loads a zero result with `illegal_op` high. A later valid legal opcode clears `illegal_op`.
- R10: While `rst_n` is low (asynchronous, active low), `out_valid`, `illegal_op` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 9 | Operation select |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| status_lo | input | 8 | Low byte of the global status register; the scale field sits in bits [7:3] |
| result | output | 64 | Registered conversion result |
| out_valid | output | 1 | `result` was loaded on the last edge |
| illegal_op | output | 1 | The last loaded opcode was undefined |

## Verification
The embedded properties assume two things about the inputs. First, opcode and operands carry known values whenever `in_valid` is high. Second, the properties that look back one cycle rely on `$past` of inputs sampled at the same edge that loaded `result`. The stimulus respects both. It changes every input only on the falling clock edge, keeps all inputs at defined values from time zero, and deliberately drives changing garbage on the opcode and operands while `in_valid` is low, to show those cycles are ignored. The corner vectors target the saturation bounds at the largest scales, where a narrow intermediate would wrap.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int OPC_W = 9;

    localparam logic [OPC_W-1:0] OPC_PACK16  = 9'h03B;
    localparam logic [OPC_W-1:0] OPC_PACK32  = 9'h03A;
    localparam logic [OPC_W-1:0] OPC_PACKFIX = 9'h03D;
    localparam logic [OPC_W-1:0] OPC_EXPAND  = 9'h04D;
    localparam logic [OPC_W-1:0] OPC_MERGE   = 9'h04B;

    typedef enum logic [2:0] {
        OPK_PACK16,
        OPK_PACK32,
        OPK_PACKFIX,
        OPK_EXPAND,
        OPK_MERGE,
        OPK_ILLEGAL
    } op_kind_e;

    typedef enum logic {
        ST_EMPTY,
        ST_FULL
    } out_state_e;

    function automatic op_kind_e decode_op(input logic [OPC_W-1:0] op);
        op_kind_e k;
        case (op)
            OPC_PACK16:  k = OPK_PACK16;
            OPC_PACK32:  k = OPK_PACK32;
            OPC_PACKFIX: k = OPK_PACKFIX;
            OPC_EXPAND:  k = OPK_EXPAND;
            OPC_MERGE:   k = OPK_MERGE;
            default:     k = OPK_ILLEGAL;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/pfc_sat_lane.sv
// One scaled, shifted and clamped lane. The intermediate is wide enough to
// hold the largest left shift without losing any bit.
module pfc_sat_lane #(
    parameter int IN_W       = 16,
    parameter int SC_W       = 4,
    parameter int RSH        = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [IN_W-1:0]  lane_in,
    input  logic [SC_W-1:0]  scale,
    output logic [OUT_W-1:0] lane_out
);
    localparam int WIDE_W = IN_W + (1 << SC_W) - 1;
    localparam longint HI_I = SIGNED_OUT ? (longint'(1) << (OUT_W-1)) - 1
                                         : (longint'(1) << OUT_W) - 1;
    localparam longint LO_I = SIGNED_OUT ? -(longint'(1) << (OUT_W-1)) : 0;
    localparam logic signed [WIDE_W-1:0] HI_W = WIDE_W'(HI_I);
    localparam logic signed [WIDE_W-1:0] LO_W = WIDE_W'(LO_I);

    logic signed [WIDE_W-1:0] ext;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [WIDE_W-1:0] shr;

    always_comb begin
        ext    = {{(WIDE_W-IN_W){lane_in[IN_W-1]}}, lane_in};
        scaled = ext <<< scale;
        shr    = scaled >>> RSH;
        if (shr > HI_W)
            lane_out = HI_W[OUT_W-1:0];
        else if (shr < LO_W)
            lane_out = LO_W[OUT_W-1:0];
        else
            lane_out = shr[OUT_W-1:0];
    end
endmodule

// File: rtl/pfc_pack_path.sv
// All three saturating pack conversions, computed in parallel.
module pfc_pack_path #(
    parameter int DATA_W = 64,
    parameter int SC16_W = 4,
    parameter int SC32_W = 5
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [SC16_W-1:0] sc16,
    input  logic [SC32_W-1:0] sc32,
    output logic [DATA_W-1:0] pack16_res,
    output logic [DATA_W-1:0] pack32_res,
    output logic [DATA_W-1:0] packfix_res
);
    localparam int HALF_W = DATA_W / 2;
    localparam int N16    = DATA_W / 16;
    localparam int N32    = DATA_W / 32;

    logic [DATA_W-1:0] a_shl;
    logic [HALF_W-1:0] p16_low;
    logic [HALF_W-1:0] pfx_low;

    assign a_shl = src_a << 8;

    for (genvar i = 0; i < N16; i++) begin : g_p16
        pfc_sat_lane #(
            .IN_W(16), .SC_W(SC16_W), .RSH(7), .OUT_W(8), .SIGNED_OUT(1'b0)
        ) u_lane (
            .lane_in (src_b[16*i +: 16]),
            .scale   (sc16),
            .lane_out(p16_low[8*i +: 8])
        );
    end

    for (genvar w = 0; w < N32; w++) begin : g_p32
        logic [7:0] sat_byte;
        pfc_sat_lane #(
            .IN_W(32), .SC_W(SC32_W), .RSH(23), .OUT_W(8), .SIGNED_OUT(1'b0)
        ) u_byte (
            .lane_in (src_b[32*w +: 32]),
            .scale   (sc32),
            .lane_out(sat_byte)
        );
        assign pack32_res[32*w +: 32] = {a_shl[32*w+8 +: 24], sat_byte};

        pfc_sat_lane #(
            .IN_W(32), .SC_W(SC32_W), .RSH(16), .OUT_W(16), .SIGNED_OUT(1'b1)
        ) u_fix (
            .lane_in (src_b[32*w +: 32]),
            .scale   (sc32),
            .lane_out(pfx_low[16*w +: 16])
        );
    end

    assign pack16_res  = {{HALF_W{1'b0}}, p16_low};
    assign packfix_res = {{HALF_W{1'b0}}, pfx_low};
endmodule

// File: rtl/pfc_rearrange.sv
// Byte widening and byte interleave of the low halves of the operands.
module pfc_rearrange #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] expand_res,
    output logic [DATA_W-1:0] merge_res
);
    localparam int NB = DATA_W / 16;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign expand_res[16*i +: 16] = {4'h0, src_b[8*i +: 8], 4'h0};
        assign merge_res[16*i +: 16]  = {src_a[8*i +: 8], src_b[8*i +: 8]};
    end
endmodule

// File: rtl/pixfmt_conv.sv
module pixfmt_conv
    import pfc_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int STAT_W    = 8,
    parameter int SCALE_LSB = 3,
    parameter int SC16_W    = 4,
    parameter int SC32_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [STAT_W-1:0] status_lo,
    output logic [DATA_W-1:0] result,
    output logic              out_valid,
    output logic              illegal_op
);
    localparam int HALF_W = DATA_W / 2;

    op_kind_e          kind;
    logic [SC16_W-1:0] sc16;
    logic [SC32_W-1:0] sc32;
    logic [DATA_W-1:0] r_p16, r_p32, r_pfx, r_exp, r_mrg;
    logic [DATA_W-1:0] next_res;
    logic              next_ill;
    out_state_e        state, state_nx;

    assign kind = decode_op(opcode);
    assign sc16 = status_lo[SCALE_LSB +: SC16_W];
    assign sc32 = status_lo[SCALE_LSB +: SC32_W];

    pfc_pack_path #(
        .DATA_W(DATA_W), .SC16_W(SC16_W), .SC32_W(SC32_W)
    ) u_pack (
        .src_a      (src_a),
        .src_b      (src_b),
        .sc16       (sc16),
        .sc32       (sc32),
        .pack16_res (r_p16),
        .pack32_res (r_p32),
        .packfix_res(r_pfx)
    );

    pfc_rearrange #(
        .DATA_W(DATA_W)
    ) u_rearr (
        .src_a     (src_a),
        .src_b     (src_b),
        .expand_res(r_exp),
        .merge_res (r_mrg)
    );

    always_comb begin
        next_ill = 1'b0;
        unique case (kind)
            OPK_PACK16:  next_res = r_p16;
            OPK_PACK32:  next_res = r_p32;
            OPK_PACKFIX: next_res = r_pfx;
            OPK_EXPAND:  next_res = r_exp;
            OPK_MERGE:   next_res = r_mrg;
            default: begin
                next_res = '0;
                next_ill = 1'b1;
            end
        endcase
    end

    // State transitions: GO_FULL on in_valid, GO_EMPTY otherwise
    always_comb begin
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_EMPTY;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            illegal_op <= 1'b0;
        end else if (in_valid) begin
            result     <= next_res;
            illegal_op <= next_ill;
        end
    end

    assign out_valid = (state == ST_FULL);

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal_op)));
    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (result == '0));
    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == OPC_PACK16 || opcode == OPC_PACKFIX))
        |=> (result[DATA_W-1:HALF_W] == '0));
    // R3
    pack32_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_PACK32)
        |=> (result[15:8] == $past(src_a[7:0])));
    // R5
    expand_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_EXPAND)
        |=> (result[3:0] == 4'h0 && result[DATA_W-1:DATA_W-4] == 4'h0));
    // R6
    merge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_MERGE)
        |=> (result[15:0] == {$past(src_a[7:0]), $past(src_b[7:0])}));
endmodule

// File: tb/pixfmt_conv_tb.sv
module pixfmt_conv_tb;

    typedef struct packed {
        logic [8:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  st;
        logic [63:0] exp_res;
        logic        exp_ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;

    localparam vec_t VTAB [NV] = '{
        // R1 scale 0, mixed lanes
        '{9'h03B, 64'h0, 64'h0080_FF80_7FFF_0100, 8'h00, 64'h0000_0000_0100_FF02, 1'b0, 4'd1},
        // R1 R7 scale 4, lane 2 overflows 16 bits before saturating
        '{9'h03B, 64'h0, 64'h8000_1000_0100_0010, 8'h20, 64'h0000_0000_00FF_2002, 1'b0, 4'd7},
        // R2 bit 7 must not reach the 16-bit pack scale
        '{9'h03B, 64'h0, 64'h0000_0000_0000_0100, 8'h80, 64'h0000_0000_0000_0002, 1'b0, 4'd2},
        // R3 scale 0
        '{9'h03A, 64'h1122_3344_5566_7788, 64'h7FFF_FFFF_0080_0000, 8'h00, 64'h2233_44FF_6677_8801, 1'b0, 4'd3},
        // R3 scale 8, negative word clamps to 0
        '{9'h03A, 64'h0, 64'hFFFF_FFFF_0001_0000, 8'h40, 64'h0000_0000_0000_0002, 1'b0, 4'd3},
        // R9 undefined opcode
        '{9'h03C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 8'hFF, 64'h0, 1'b1, 4'd9},
        // R2 bit 7 does reach the 32-bit pack scale (16); R9 flag clears
        '{9'h03A, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0100, 8'h80, 64'hFFFF_FF00_FFFF_FF02, 1'b0, 4'd2},
        // R7 scale 31 would wrap a 32-bit intermediate
        '{9'h03A, 64'h0, 64'h0000_0002_0000_0001, 8'hF8, 64'h0000_00FF_0000_00FF, 1'b0, 4'd7},
        // R4 scale 0
        '{9'h03D, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFE_0000_0001_2345, 8'h00, 64'h0000_0000_FFFE_0001, 1'b0, 4'd4},
        // R4 scale 16, both bounds
        '{9'h03D, 64'h0, 64'hFFFF_7FFF_0000_8000, 8'h80, 64'h0000_0000_8000_7FFF, 1'b0, 4'd4},
        // R7 scale 31 on fixed-point pack
        '{9'h03D, 64'h0, 64'hFFFF_FFFF_0000_0003, 8'hF8, 64'h0000_0000_8000_7FFF, 1'b0, 4'd7},
        // R9 opcode zero is undefined
        '{9'h000, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 8'h18, 64'h0, 1'b1, 4'd9},
        // R5 expand, upper half and src_a ignored
        '{9'h04D, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_F00F_8001, 8'hFF, 64'h0F00_00F0_0800_0010, 1'b0, 4'd5},
        // R6 merge, upper halves ignored
        '{9'h04B, 64'h1111_2222_A3A2_A1A0, 64'h3333_4444_B3B2_B1B0, 8'h00, 64'hA3B3_A2B2_A1B1_A0B0, 1'b0, 4'd6},
        // R5 extreme bytes
        '{9'h04D, 64'h0, 64'h0000_0000_FF00_00FF, 8'h00, 64'h0FF0_0000_0000_0FF0, 1'b0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [8:0]  opcode;
    logic [63:0] src_a, src_b;
    logic [7:0]  status_lo;
    logic [63:0] result;
    logic        out_valid;
    logic        illegal_op;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pixfmt_conv u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .src_a     (src_a),
        .src_b     (src_b),
        .status_lo (status_lo),
        .result    (result),
        .out_valid (out_valid),
        .illegal_op(illegal_op)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        opcode    = v.op;
        src_a     = v.a;
        src_b     = v.b;
        status_lo = v.st;
        in_valid  = vld;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(VTAB[0], 1'b0);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", 64'(out_valid), 64'h0);
        chk("R10 result", result, 64'h0);
        chk("R10 illegal_op", 64'(illegal_op), 64'h0);
        rst_n = 1'b1;

        @(negedge clk);
        drive(VTAB[0], 1'b1);
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            chk($sformatf("R%0d vec%0d result", VTAB[k].req, k), result, VTAB[k].exp_res);
            chk($sformatf("R9 vec%0d illegal_op", k), 64'(illegal_op), 64'(VTAB[k].exp_ill));
            chk($sformatf("R8 vec%0d out_valid", k), 64'(out_valid), 64'h1);
            if (k < NV-1) drive(VTAB[k+1], 1'b1);
            else          drive(VTAB[5], 1'b0);
        end

        // R8 idle cycles ignore an undefined opcode and changing data
        @(negedge clk);
        chk("R8 idle out_valid", 64'(out_valid), 64'h0);
        chk("R8 idle result hold", result, VTAB[NV-1].exp_res);
        chk("R8 idle illegal_op hold", 64'(illegal_op), 64'h0);
        drive(VTAB[3], 1'b0);
        @(negedge clk);
        chk("R8 idle2 result hold", result, VTAB[NV-1].exp_res);

        // R9 illegal then legal clears the flag
        drive(VTAB[11], 1'b1);
        @(negedge clk);
        chk("R9 illegal flag", 64'(illegal_op), 64'h1);
        chk("R9 illegal result", result, 64'h0);
        drive(VTAB[2], 1'b1);
        @(negedge clk);
        chk("R9 flag cleared", 64'(illegal_op), 64'h0);
        chk("R2 repeat result", result, VTAB[2].exp_res);
        drive(VTAB[0], 1'b0);

        // R10 asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1;
        chk("R10 async result", result, 64'h0);
        chk("R10 async out_valid", 64'(out_valid), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule